// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a parameterised number of sources and decides which one the CPU should take next. Every source owns an 8-bit control register. The register holds a pending flag, an enable, a routing bit and a 4-bit priority level. A source becomes pending either on a one-cycle hardware event pulse or through a software write to its register. It stays pending until it is acknowledged or until software clears it.

The controller first finds the enabled, CPU-routed pending source with the highest level. It then offers that source to the CPU only when its level is strictly above the level of the service now running. When the CPU acknowledges, the block clears the pending flag in hardware, saves the running level on a nesting stack, and raises the running level to that of the new service. A return pulse from the CPU restores the saved level.

Two further paths sit beside this one. A software trap carries an explicit vector number and is taken ahead of all hardware sources. A source whose routing bit is set never interrupts the CPU. Instead it is presented on a separate one-cycle data-transfer channel, which has its own acknowledge.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset every control register reads 0x00, the running level is 0, and both `irq_req_o` and `xfer_req_o` are low.
- R2: A write to a source's control register loads its fields. The pending flag is bit 7, the enable is bit 6, route-to-transfer is bit 5, and the level is bits 3:0. Bit 4 always reads 0. `reg_rdata_o` shows the register selected by `reg_addr_i` in the same cycle.
- R3: A one-cycle pulse on `evt_i[n]` sets the pending flag of source n. The flag then stays set until an acknowledge takes it or software writes bit 7 as 0.
- R4: A source can compete for the CPU only if all of these hold: it is pending, it is enabled, its route bit is 0, and its level is not 0. A level-0 source or a disabled source never raises `irq_req_o`.
- R5: Among the competing sources, the one with the highest level wins. When levels are equal, the lower source index wins. `irq_vec_o` gives the winner's index and `irq_lvl_o` gives its level.
- R6: A hardware request is offered on `irq_req_o` only when its level is strictly greater than the running level `cur_lvl_o`. A request at an equal level waits.
- R7: An acknowledge on a cycle with `irq_req_o` high does three things for a hardware winner. It clears that source's pending flag, pushes the running level onto the nesting stack, and makes the winner's level the running level.
- R8: A `reti_i` pulse pops the nesting stack into the running level. With an empty stack it has no effect, and the running level is then 0.
- R9: A `trap_i` pulse latches `trap_vec_i`. The pending trap takes precedence over hardware sources and ignores enable and level. It presents its number on `irq_vec_o` with `irq_lvl_o` equal to the running level. Its acknowledge pushes the running level and leaves that level unchanged.
- R10: Sources that are pending, enabled and routed drive `xfer_req_o`, and `xfer_src_o` names the lowest such index. `xfer_ack_i` clears that source's pending flag. A routed source never raises `irq_req_o`.
- R11: While the nesting stack holds 16 entries, `irq_req_o` stays low. The request reappears after a `reti_i`.
- R12: When `irq_ack_i` and `reti_i` arrive in the same cycle, the acknowledge is ignored. The request stays pending and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Per-source hardware event pulses |
| reg_we_i | input | 1 | Control register write strobe |
| reg_addr_i | input | SRC_W | Control register select |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Selected control register contents |
| trap_i | input | 1 | Software trap pulse |
| trap_vec_i | input | VEC_W | Trap vector number |
| irq_req_o | output | 1 | Interrupt offered to the CPU |
| irq_vec_o | output | VEC_W | Vector number of the offered interrupt |
| irq_lvl_o | output | 4 | Level of the offered interrupt |
| irq_ack_i | input | 1 | CPU accepts the offered interrupt |
| reti_i | input | 1 | Return-from-interrupt pulse |
| cur_lvl_o | output | 4 | Level of the service now running |
| xfer_req_o | output | 1 | Request to the data-transfer channel |
| xfer_src_o | output | SRC_W | Source served by the transfer channel |
| xfer_ack_i | input | 1 | Transfer channel completed a service |

## Verification
The hardest state to reach is a full nesting stack. Hardware sources can climb through at most fifteen strictly increasing levels above zero, so they alone can never fill all sixteen entries. The stimulus therefore fills the stack with a chain of software traps, each acknowledged at the same running level. It then raises one more trap and checks that the request is held back until a single return frees an entry. A second awkward case is an acknowledge that lands in the same cycle as a return; the bench drives both at once and then reads the source's register back to confirm that its flag survived.

// File: rtl/nic_pkg.sv
`timescale 1ns/1ps
package nic_pkg;
  localparam int unsigned LVL_W     = 4;
  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned BIT_PEND  = 7;
  localparam int unsigned BIT_EN    = 6;
  localparam int unsigned BIT_ROUTE = 5;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic pend;
    logic en;
    logic route;
    lvl_t lvl;
  } src_ctrl_t;

  function automatic logic [CTRL_W-1:0] ctrl_to_bits(src_ctrl_t c);
    return {c.pend, c.en, c.route, 1'b0, c.lvl};
  endfunction
endpackage

// File: rtl/nic_src_regs.sv
`timescale 1ns/1ps
module nic_src_regs
  import nic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0]            evt_i,
  input  logic [NUM_SRC-1:0]            clr_i,
  input  logic                          we_i,
  input  logic [SRC_W-1:0]              addr_i,
  input  logic [CTRL_W-1:0]             wdata_i,
  output src_ctrl_t [NUM_SRC-1:0]       ctrl_o,
  output logic [CTRL_W-1:0]             rdata_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    src_ctrl_t q;
    logic      sel;

    assign sel       = we_i && (addr_i == SRC_W'(g));
    assign ctrl_o[g] = q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (sel) begin
        q.pend  <= wdata_i[BIT_PEND] | evt_i[g];
        q.en    <= wdata_i[BIT_EN];
        q.route <= wdata_i[BIT_ROUTE];
        q.lvl   <= wdata_i[LVL_W-1:0];
      end else begin
        // a new event beats a same-cycle clear
        q.pend <= (q.pend & ~clr_i[g]) | evt_i[g];
      end
    end

    a_r3_pend_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q.pend && !clr_i[g] && !sel |=> q.pend);
    a_r3_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> q.pend);
  end

  always_comb begin
    rdata_o = '0;
    if (32'(addr_i) < NUM_SRC) rdata_o = ctrl_to_bits(ctrl_o[addr_i]);
  end

endmodule

// File: rtl/nic_arbiter.sv
`timescale 1ns/1ps
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned SRC_W   = $clog2(NUM_SRC)
) (
  input  src_ctrl_t [NUM_SRC-1:0] ctrl_i,
  output logic                    cpu_valid_o,
  output logic [SRC_W-1:0]        cpu_idx_o,
  output lvl_t                    cpu_lvl_o,
  output logic [NUM_SRC-1:0]      cpu_gnt_o,
  output logic                    xfer_valid_o,
  output logic [SRC_W-1:0]        xfer_idx_o,
  output logic [NUM_SRC-1:0]      xfer_gnt_o
);

  logic [NUM_SRC-1:0] cpu_elig, xfer_elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign cpu_elig[g]  = ctrl_i[g].pend && ctrl_i[g].en && !ctrl_i[g].route &&
                          (ctrl_i[g].lvl != '0);
    assign xfer_elig[g] = ctrl_i[g].pend && ctrl_i[g].en && ctrl_i[g].route;
  end

  // strict compare keeps the lower index on equal levels
  always_comb begin
    logic             v;
    logic [SRC_W-1:0] idx;
    lvl_t             best;
    v    = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cpu_elig[i] && (!v || ctrl_i[i].lvl > best)) begin
        v    = 1'b1;
        idx  = SRC_W'(i);
        best = ctrl_i[i].lvl;
      end
    end
    cpu_valid_o = v;
    cpu_idx_o   = idx;
    cpu_lvl_o   = best;
  end

  always_comb begin
    logic             v;
    logic [SRC_W-1:0] idx;
    v   = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (xfer_elig[i]) begin
        v   = 1'b1;
        idx = SRC_W'(i);
      end
    end
    xfer_valid_o = v;
    xfer_idx_o   = idx;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gnt
    assign cpu_gnt_o[g]  = cpu_valid_o && (cpu_idx_o == SRC_W'(g));
    assign xfer_gnt_o[g] = xfer_valid_o && (xfer_idx_o == SRC_W'(g));
  end

endmodule

// File: rtl/nic_lvl_stack.sv
`timescale 1ns/1ps
module nic_lvl_stack
  import nic_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  lvl_t push_lvl_i,
  input  logic pop_i,
  output lvl_t top_o,
  output logic empty_o,
  output logic full_o
);

  localparam int unsigned SP_W  = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t             mem_q [DEPTH];
  logic [SP_W-1:0]  sp_q;
  logic [IDX_W-1:0] wr_idx, top_idx;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign wr_idx  = IDX_W'(sp_q);
  assign top_idx = IDX_W'(sp_q - 1'b1);
  assign top_o   = empty_o ? '0 : mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   sp_q <= '0;
    else if (push_i && !full_o)    sp_q <= sp_q + 1'b1;
    else if (pop_i && !empty_o)    sp_q <= sp_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wr_idx] <= push_lvl_i;
  end

  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r8_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !empty_o && !push_i |=> sp_q == SP_W'($past(sp_q) - 1'b1));

endmodule

// File: rtl/nested_irq_ctrl.sv
`timescale 1ns/1ps
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 16,
  parameter int unsigned STK_DEPTH = 16,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned SRC_W     = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               reg_we_i,
  input  logic [SRC_W-1:0]   reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic               trap_i,
  input  logic [VEC_W-1:0]   trap_vec_i,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic [3:0]         irq_lvl_o,
  input  logic               irq_ack_i,
  input  logic               reti_i,
  output logic [3:0]         cur_lvl_o,
  output logic               xfer_req_o,
  output logic [SRC_W-1:0]   xfer_src_o,
  input  logic               xfer_ack_i
);

  src_ctrl_t [NUM_SRC-1:0] ctrl;
  logic [NUM_SRC-1:0]      clr, cpu_gnt, xfer_gnt;
  logic                    cpu_valid, xfer_valid;
  logic [SRC_W-1:0]        cpu_idx;
  lvl_t                    cpu_lvl, cur_lvl_q, stk_top;
  logic                    stk_empty, stk_full;
  logic                    trap_pend_q;
  logic [VEC_W-1:0]        trap_vec_q;
  logic                    take, take_hw, take_trap, do_pop;

  nic_src_regs #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .clr_i   (clr),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl),
    .rdata_o (reg_rdata_o)
  );

  nic_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_arb (
    .ctrl_i       (ctrl),
    .cpu_valid_o  (cpu_valid),
    .cpu_idx_o    (cpu_idx),
    .cpu_lvl_o    (cpu_lvl),
    .cpu_gnt_o    (cpu_gnt),
    .xfer_valid_o (xfer_valid),
    .xfer_idx_o   (xfer_src_o),
    .xfer_gnt_o   (xfer_gnt)
  );

  nic_lvl_stack #(.DEPTH(STK_DEPTH)) i_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .push_lvl_i (cur_lvl_q),
    .pop_i      (do_pop),
    .top_o      (stk_top),
    .empty_o    (stk_empty),
    .full_o     (stk_full)
  );

  assign irq_req_o  = !stk_full && (trap_pend_q || (cpu_valid && cpu_lvl > cur_lvl_q));
  assign irq_vec_o  = trap_pend_q ? trap_vec_q : VEC_W'(cpu_idx);
  assign irq_lvl_o  = trap_pend_q ? cur_lvl_q : cpu_lvl;
  assign cur_lvl_o  = cur_lvl_q;
  assign xfer_req_o = xfer_valid;

  // return wins over a same-cycle acknowledge
  assign take      = irq_ack_i && irq_req_o && !reti_i;
  assign take_trap = take && trap_pend_q;
  assign take_hw   = take && !trap_pend_q;
  assign do_pop    = reti_i && !stk_empty;

  assign clr = (take_hw ? cpu_gnt : '0) | ((xfer_ack_i && xfer_valid) ? xfer_gnt : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_lvl_q <= '0;
    else if (take)   cur_lvl_q <= irq_lvl_o;
    else if (do_pop) cur_lvl_q <= stk_top;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_pend_q <= 1'b0;
      trap_vec_q  <= '0;
    end else if (trap_i && (!trap_pend_q || take_trap)) begin
      trap_pend_q <= 1'b1;
      trap_vec_q  <= trap_vec_i;
    end else if (take_trap) begin
      trap_pend_q <= 1'b0;
    end
  end

  a_r6_level_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_hw |=> cur_lvl_q > $past(cur_lvl_q));
  a_r4_no_level_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && !trap_pend_q |-> cpu_lvl != '0);
  a_r8_empty_is_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_empty |-> cur_lvl_q == '0);
  a_r9_trap_keeps_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_trap |=> cur_lvl_q == $past(cur_lvl_q));
  a_r10_paths_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_gnt & xfer_gnt) == '0);
  a_r7_winner_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_hw && !evt_i[cpu_idx] && !reg_we_i |=> !ctrl[$past(cpu_idx)].pend);

endmodule

// File: tb/test_nested_irq_ctrl.sv
`timescale 1ns/1ps
module test_nested_irq_ctrl;
  localparam int unsigned N  = 16;
  localparam int unsigned SW = 4;
  localparam int unsigned VW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          reg_we_i = 1'b0;
  logic [SW-1:0] reg_addr_i = '0;
  logic [7:0]    reg_wdata_i = '0;
  logic [7:0]    reg_rdata_o;
  logic          trap_i = 1'b0;
  logic [VW-1:0] trap_vec_i = '0;
  logic          irq_req_o;
  logic [VW-1:0] irq_vec_o;
  logic [3:0]    irq_lvl_o;
  logic          irq_ack_i = 1'b0;
  logic          reti_i = 1'b0;
  logic [3:0]    cur_lvl_o;
  logic          xfer_req_o;
  logic [SW-1:0] xfer_src_o;
  logic          xfer_ack_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int    exp_vec_q[$];
  int    exp_lvl_q[$];
  string exp_tag_q[$];

  always #4 clk = ~clk;

  nested_irq_ctrl #(.NUM_SRC(N), .STK_DEPTH(16), .VEC_W(VW)) i_nested_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .trap_i(trap_i), .trap_vec_i(trap_vec_i), .irq_req_o(irq_req_o),
    .irq_vec_o(irq_vec_o), .irq_lvl_o(irq_lvl_o), .irq_ack_i(irq_ack_i),
    .reti_i(reti_i), .cur_lvl_o(cur_lvl_o), .xfer_req_o(xfer_req_o),
    .xfer_src_o(xfer_src_o), .xfer_ack_i(xfer_ack_i)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we_i = 1'b1; reg_addr_i = SW'(a); reg_wdata_i = 8'(d);
    @(negedge clk); reg_we_i = 1'b0; #1;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); reg_addr_i = SW'(a); #1;
    chk(reg_rdata_o, exp, tag);
  endtask

  task automatic expect_irq(input int v, input int l, input string tag);
    exp_vec_q.push_back(v); exp_lvl_q.push_back(l); exp_tag_q.push_back(tag);
  endtask

  task automatic do_ack();
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0; #1;
  endtask

  task automatic do_reti();
    @(negedge clk); reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0; #1;
  endtask

  task automatic do_trap(input int v);
    @(negedge clk); trap_i = 1'b1; trap_vec_i = VW'(v);
    @(negedge clk); trap_i = 1'b0; #1;
  endtask

  task automatic pulse_evt(input int s);
    @(negedge clk); evt_i[s] = 1'b1;
    @(negedge clk); evt_i[s] = 1'b0; #1;
  endtask

  task automatic do_xack();
    @(negedge clk); xfer_ack_i = 1'b1;
    @(negedge clk); xfer_ack_i = 1'b0; #1;
  endtask

  // scoreboard monitor: compares every accepted acknowledge
  initial forever begin
    @(negedge clk); #1;
    if (irq_ack_i && !reti_i) begin
      if (exp_vec_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: unexpected acknowledge, actual vec %0d expected none", irq_vec_o);
      end else begin
        string t;
        t = exp_tag_q.pop_front();
        chk(irq_req_o, 1, t);
        chk(irq_vec_o, exp_vec_q.pop_front(), t);
        chk(irq_lvl_o, exp_lvl_q.pop_front(), t);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; #1;
    // R1 reset state
    chk(irq_req_o, 0, "R1 irq"); chk(xfer_req_o, 0, "R1 xfer"); chk(cur_lvl_o, 0, "R1 lvl");
    for (int i = 0; i < N; i++) rd(i, 0, "R1 reg");

    // R2 layout, R5 vector, R7 acknowledge
    wr(3, 8'hC5); rd(3, 8'hC5, "R2 readback");
    chk(irq_req_o, 1, "R5 req");
    expect_irq(3, 5, "R5 single"); do_ack();
    chk(cur_lvl_o, 5, "R7 level"); rd(3, 8'h45, "R7 pend cleared");

    // R6 strict preemption, R8 nesting
    wr(4, 8'hC5); chk(irq_req_o, 0, "R6 equal level waits");
    wr(9, 8'hC6); chk(irq_req_o, 1, "R6 higher offered");
    expect_irq(9, 6, "R6 nest"); do_ack(); chk(cur_lvl_o, 6, "R7 nested level");
    do_reti(); chk(cur_lvl_o, 5, "R8 pop");
    do_reti(); chk(cur_lvl_o, 0, "R8 pop base");
    do_reti(); chk(cur_lvl_o, 0, "R8 empty pop");
    expect_irq(4, 5, "R6 released"); do_ack(); do_reti();

    // R4 eligibility
    wr(1, 8'hC0); chk(irq_req_o, 0, "R4 level zero");
    wr(2, 8'h87); chk(irq_req_o, 0, "R4 disabled");
    wr(1, 8'h00); wr(2, 8'h00);

    // R5 tie and higher level
    wr(6, 8'hC7); wr(2, 8'hC7);
    expect_irq(2, 7, "R5 tie low index"); do_ack();
    chk(irq_req_o, 0, "R6 equal after ack");
    do_reti(); expect_irq(6, 7, "R5 tie second"); do_ack(); do_reti();
    wr(10, 8'hC3); wr(12, 8'hCB);
    expect_irq(12, 11, "R5 higher wins"); do_ack(); do_reti();
    expect_irq(10, 3, "R5 lower next"); do_ack(); do_reti();

    // R3 event pulses and software clear
    wr(7, 8'h44); chk(irq_req_o, 0, "R3 idle");
    pulse_evt(7); rd(7, 8'hC4, "R3 event sets");
    repeat (5) @(negedge clk);
    rd(7, 8'hC4, "R3 held"); chk(irq_req_o, 1, "R3 req");
    expect_irq(7, 4, "R3 service"); do_ack(); rd(7, 8'h44, "R3 acked"); do_reti();
    pulse_evt(7); wr(7, 8'h44); rd(7, 8'h44, "R3 sw clear"); chk(irq_req_o, 0, "R3 sw clear req");

    // R2 reserved bit, R10 transfer routing
    wr(8, 8'hFF); rd(8, 8'hEF, "R2 reserved bit");
    chk(xfer_req_o, 1, "R10 xfer req"); chk(xfer_src_o, 8, "R10 xfer src");
    chk(irq_req_o, 0, "R10 no cpu");
    do_xack(); rd(8, 8'h6F, "R10 xfer cleared"); chk(xfer_req_o, 0, "R10 xfer idle");
    wr(13, 8'hE1); wr(11, 8'hE9);
    chk(xfer_src_o, 11, "R10 lowest index"); do_xack();
    chk(xfer_src_o, 13, "R10 next"); do_xack(); chk(xfer_req_o, 0, "R10 drained");

    // R9 software trap
    wr(5, 8'hCF); expect_irq(5, 15, "R9 setup"); do_ack();
    do_trap(8'h40); chk(irq_req_o, 1, "R9 trap bypasses level");
    expect_irq(8'h40, 15, "R9 trap vec"); do_ack(); chk(cur_lvl_o, 15, "R9 level kept");
    do_reti(); chk(cur_lvl_o, 15, "R9 pop");
    do_reti(); chk(cur_lvl_o, 0, "R9 pop base");
    wr(3, 8'hC2); do_trap(8'h21);
    expect_irq(8'h21, 0, "R9 trap first"); do_ack();
    expect_irq(3, 2, "R9 hw after trap"); do_ack(); do_reti(); do_reti();

    // R11 stack full
    for (int i = 0; i < 16; i++) begin
      do_trap(i + 1); expect_irq(i + 1, 0, "R11 fill"); do_ack();
    end
    do_trap(8'h77); chk(irq_req_o, 0, "R11 full blocks");
    do_reti(); chk(irq_req_o, 1, "R11 released");
    expect_irq(8'h77, 0, "R11 last trap"); do_ack();
    for (int i = 0; i < 16; i++) do_reti();
    chk(cur_lvl_o, 0, "R11 unwound"); chk(irq_req_o, 0, "R11 idle");

    // R12 ack collides with reti
    wr(14, 8'hC9);
    @(negedge clk); irq_ack_i = 1'b1; reti_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0; reti_i = 1'b0; #1;
    chk(irq_req_o, 1, "R12 still offered"); chk(cur_lvl_o, 0, "R12 level");
    rd(14, 8'hC9, "R12 pend kept");
    expect_irq(14, 9, "R12 later ack"); do_ack(); do_reti();

    repeat (2) @(negedge clk);
    chk(exp_vec_q.size(), 0, "R5 scoreboard drained");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule